// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a pipelined synchronous SRAM. It holds a parameterised array of 36-bit words, and each word is split into four 9-bit byte lanes. Address and command are captured on a rising clock edge. The data transfer for that command, read or write, takes place exactly two cycles later. Reads and writes therefore share one fixed pipeline. A bus master can mix them on consecutive cycles and the bus never needs an idle turnaround cycle.

A load/advance input chooses between two actions. It either loads a new external address and command, or steps an internal two-bit burst counter, which yields four words from one loaded address in linear or interleaved order. Three chip enables gate new operations. A clock enable freezes the whole block. Per-lane write selects mask writes, and an asynchronous output enable can turn the output drivers off. The data bus is modelled as a separate input and output with a drive-enable flag.

Top module: `zt_sram`

## Requirements
- R1: For a command sampled at rising edge n, write data is taken from `data_i` at edge n+2. Read data is held on `data_o`, with `data_oe_o` high, during the cycle that ends at edge n+2.
- R2: Reads and writes may alternate on consecutive cycles with no idle cycle. A read issued the cycle after a write to the same address returns the newly written data.
- R3: While `clk_en_ni` is high, all other synchronous inputs are ignored and every register holds its value: pipeline stages, burst state, memory and outputs.
- R4: With `load_ni` low, a new address and command are loaded. `rd_wr_i` high means read and low means write.
- R5: With `load_ni` high during an active burst, the next word address is produced. The upper address bits stay equal to the loaded address. The low two bits become (base + k) mod 4 when `burst_lin_i` is 1, or base XOR k when it is 0, for k = 1, 2, 3. The sequence then wraps.
- R6: Advance cycles reuse the direction and lane selects captured at the last load. An advance with no active burst starts nothing: there is no write, and the bus is not driven in its data slot.
- R7: `sel_a_ni` and `sel_c_ni` are active low, and `sel_b_i` is active high. If any of them is inactive on a load cycle, no operation starts and the active burst ends. Transfers already in the pipeline still complete.
- R8: `data_oe_o` is low during the data slot of every write and of every deselected or idle cycle.
- R9: A write updates lane i, which is bits 9i+8 down to 9i, only when `byte_we_ni[i]` is low. The other lanes keep their old contents.
- R10: `out_en_ni` high forces `data_oe_o` low at once, without a clock edge. The pipeline is not disturbed, so the following read slots deliver correct data.
- R11: After reset, `data_oe_o` is low and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_ni | input | 1 | Clock enable, active low |
| load_ni | input | 1 | Low: load new address; high: advance burst |
| rd_wr_i | input | 1 | 1 read, 0 write |
| sel_a_ni | input | 1 | Chip enable, active low |
| sel_b_i | input | 1 | Chip enable, active high |
| sel_c_ni | input | 1 | Chip enable, active low |
| burst_lin_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| out_en_ni | input | 1 | Asynchronous output enable, active low |
| byte_we_ni | input | LANES | Per-lane write select, active low |
| addr_i | input | ADDR_W | Word address |
| data_i | input | LANES*LANE_W | Write data for the current data slot |
| data_o | output | LANES*LANE_W | Read data |
| data_oe_o | output | 1 | Read data is being driven |

## Verification
Single writes followed by reads of several addresses check the basic two-cycle latency. A strict write/read alternation on a shared address separates a correct same-address forward from a stale array read. A full write followed by a masked rewrite shows whether the lane selects are decoded correctly. A linear write burst read back in interleaved order from a different base address tells the two orders apart, and also shows any carry into the upper address bits. A burst that stalls for two cycles, with a conflicting write presented during the stall, a deselect issued while a write and a read are still pending, and an output-enable pulse over a read slot check that the pipeline holds, drains and is not disturbed.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

  typedef enum logic {
    ORDER_IL  = 1'b0,
    ORDER_LIN = 1'b1
  } burst_order_e;

  typedef struct packed {
    logic valid;
    logic rd;
  } op_t;

  // next low address bits of a 4-word burst
  function automatic logic [1:0] step_low(logic [1:0] base, logic [1:0] step,
                                          burst_order_e ord);
    return (ord == ORDER_LIN) ? base + step : base ^ step;
  endfunction

endpackage

// File: rtl/zt_burst_gen.sv
module zt_burst_gen
  import zt_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic              sel_ok_i,
  input  logic              rd_i,
  input  logic [LANES-1:0]  be_n_i,
  input  logic              lin_i,
  input  logic [ADDR_W-1:0] addr_i,
  output op_t               op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANES-1:0]  be_n_o,
  output logic              act_o
);

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q, cnt_nxt;
  logic              rd_q, act_q;
  logic [LANES-1:0]  be_q;

  assign cnt_nxt = cnt_q + 2'd1;
  assign act_o   = act_q;

  always_comb begin
    if (load_i) begin
      op_o   = '{valid: sel_ok_i, rd: rd_i};
      addr_o = addr_i;
      be_n_o = be_n_i;
    end else begin
      op_o   = '{valid: act_q, rd: rd_q};
      addr_o = {base_q[ADDR_W-1:2],
                step_low(base_q[1:0], cnt_nxt, burst_order_e'(lin_i))};
      be_n_o = be_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
      rd_q   <= 1'b0;
      be_q   <= '1;
    end else if (en_i) begin
      if (load_i) begin
        act_q <= sel_ok_i;
        if (sel_ok_i) begin
          base_q <= addr_i;
          cnt_q  <= '0;
          rd_q   <= rd_i;
          be_q   <= be_n_i;
        end
      end else if (act_q) begin
        cnt_q <= cnt_nxt;
      end
    end
  end

  assert_upper_fixed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && !load_i && $past(en_i && load_i && sel_ok_i))
      |-> addr_o[ADDR_W-1:2] == $past(addr_i[ADDR_W-1:2]));

endmodule

// File: rtl/zt_mem_array.sv
module zt_mem_array #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9,
  localparam int unsigned DEPTH = 1 << ADDR_W,
  localparam int unsigned WORD_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [LANES-1:0]  wbe_n_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WORD_W-1:0] rdata_o
);

  logic hit;
  assign hit = wr_i && (waddr_i == raddr_i);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] lane_q [DEPTH];
    logic              lane_wr;

    assign lane_wr = wr_i && !wbe_n_i[l];

    always_ff @(posedge clk_i) begin
      if (lane_wr) lane_q[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    // forward a write landing on the same edge as the read
    assign rdata_o[l*LANE_W +: LANE_W] = (hit && !wbe_n_i[l])
                                         ? wdata_i[l*LANE_W +: LANE_W]
                                         : lane_q[raddr_i];
  end

endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9,
  localparam int unsigned WORD_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_en_ni,
  input  logic              load_ni,
  input  logic              rd_wr_i,
  input  logic              sel_a_ni,
  input  logic              sel_b_i,
  input  logic              sel_c_ni,
  input  logic              burst_lin_i,
  input  logic              out_en_ni,
  input  logic [LANES-1:0]  byte_we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] data_o,
  output logic              data_oe_o
);

  logic              en, sel_ok, burst_act, mem_wr;
  op_t               nxt_op, s1_op, s2_op;
  logic [ADDR_W-1:0] nxt_addr, s1_addr, s2_addr;
  logic [LANES-1:0]  nxt_be_n, s1_be_n, s2_be_n;
  logic [WORD_W-1:0] rdata, dout_q;
  logic              oe_q;

  assign en     = !clk_en_ni;
  assign sel_ok = !sel_a_ni && sel_b_i && !sel_c_ni;

  zt_burst_gen #(.ADDR_W(ADDR_W), .LANES(LANES)) u_burst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en),
    .load_i  (!load_ni),
    .sel_ok_i(sel_ok),
    .rd_i    (rd_wr_i),
    .be_n_i  (byte_we_ni),
    .lin_i   (burst_lin_i),
    .addr_i  (addr_i),
    .op_o    (nxt_op),
    .addr_o  (nxt_addr),
    .be_n_o  (nxt_be_n),
    .act_o   (burst_act)
  );

  // two-stage command pipeline: s1 = address slot, s2 = data slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_op   <= '0;
      s2_op   <= '0;
      s1_addr <= '0;
      s2_addr <= '0;
      s1_be_n <= '1;
      s2_be_n <= '1;
    end else if (en) begin
      s1_op   <= nxt_op;
      s1_addr <= nxt_addr;
      s1_be_n <= nxt_be_n;
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
      s2_be_n <= s1_be_n;
    end
  end

  assign mem_wr = en && s2_op.valid && !s2_op.rd;

  zt_mem_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk_i  (clk_i),
    .wr_i   (mem_wr),
    .waddr_i(s2_addr),
    .wdata_i(data_i),
    .wbe_n_i(s2_be_n),
    .raddr_i(s1_addr),
    .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q   <= 1'b0;
      dout_q <= '0;
    end else if (en) begin
      oe_q <= s1_op.valid && s1_op.rd;
      if (s1_op.valid && s1_op.rd) dout_q <= rdata;
    end
  end

  assign data_o    = dout_q;
  assign data_oe_o = oe_q && !out_en_ni;

  assert_stall_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_ni |=> ($stable(s1_op) && $stable(s2_op) && $stable(oe_q)
                   && $stable(dout_q) && $stable(burst_act)));

  assert_deselect_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !load_ni && !sel_ok) |=> !s1_op.valid);

  assert_adv_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && load_ni && !burst_act) |=> !s1_op.valid);

  assert_write_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s2_op.valid && !s2_op.rd) |-> !oe_q);

  assert_read_slot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && s1_op.valid && s1_op.rd) |=> oe_q);

endmodule

// File: tb/zt_sram_test.sv
`timescale 1ns/1ps
module zt_sram_test;

  typedef struct {
    bit          act;
    bit          rd;
    int          addr;
    logic [35:0] wd;
    logic [3:0]  be_n;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en_ni = 1'b0, load_ni = 1'b1, rd_wr_i = 1'b1;
  logic        sel_a_ni = 1'b0, sel_b_i = 1'b1, sel_c_ni = 1'b0;
  logic        burst_lin_i = 1'b1, out_en_ni = 1'b0;
  logic [3:0]  byte_we_ni = 4'h0;
  logic [5:0]  addr_i = '0;
  logic [35:0] data_i = '0;
  logic [35:0] data_o;
  logic        data_oe_o;

  int checks = 0, fails = 0;
  logic [35:0] ref_mem [64];
  item_t pend[$];
  bit b_act = 0, b_rd = 0;
  int b_base = 0, b_cnt = 0;
  logic [3:0] b_be = 4'h0;

  localparam logic [2:0] SEL_OK = 3'b010;

  always #4 clk = ~clk;

  zt_sram uut (
    .clk_i(clk), .rst_ni(rst_n), .clk_en_ni(clk_en_ni), .load_ni(load_ni),
    .rd_wr_i(rd_wr_i), .sel_a_ni(sel_a_ni), .sel_b_i(sel_b_i), .sel_c_ni(sel_c_ni),
    .burst_lin_i(burst_lin_i), .out_en_ni(out_en_ni), .byte_we_ni(byte_we_ni),
    .addr_i(addr_i), .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o)
  );

  task automatic chk(bit ok, string tag, string what, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one bus cycle: monitor the current data slot, then drive the next command
  task automatic cyc(string tag, bit ce_n, bit ld_n, bit rd, int addr,
                     logic [3:0] be_n, logic [2:0] sel, bit oe_n);
    item_t slot, it;
    bit exp_oe;
    logic [63:0] r;
    @(negedge clk);
    out_en_ni = oe_n;
    #1;
    slot.act = 0; slot.rd = 0; slot.tag = tag;
    if (pend.size() == 2) slot = pend[0];
    exp_oe = slot.act && slot.rd && !oe_n;
    chk(data_oe_o === exp_oe, oe_n ? tag : slot.tag, "data_oe_o",
        {35'd0, data_oe_o}, {35'd0, exp_oe});
    if (exp_oe)
      chk(data_o === ref_mem[slot.addr], slot.tag, "data_o", data_o, ref_mem[slot.addr]);
    data_i = (slot.act && !slot.rd) ? slot.wd : 36'h0;
    clk_en_ni = ce_n; load_ni = ld_n; rd_wr_i = rd; addr_i = addr[5:0];
    byte_we_ni = be_n; {sel_a_ni, sel_b_i, sel_c_ni} = sel;
    @(posedge clk);
    if (!ce_n) begin
      it.act = 0; it.rd = 0; it.addr = 0; it.wd = '0; it.be_n = 4'hf; it.tag = tag;
      if (!ld_n) begin
        if (sel == SEL_OK) begin
          b_act = 1; b_base = addr; b_cnt = 0; b_rd = rd; b_be = be_n;
          it.act = 1; it.rd = rd; it.addr = addr; it.be_n = be_n;
        end else b_act = 0;
      end else if (b_act) begin
        b_cnt = (b_cnt + 1) & 3;
        it.act = 1; it.rd = b_rd; it.be_n = b_be;
        it.addr = (b_base & ~3) |
                  (burst_lin_i ? ((b_base + b_cnt) & 3) : ((b_base & 3) ^ b_cnt));
      end
      if (it.act && !it.rd) begin
        r = {$urandom(), $urandom()};
        it.wd = r[35:0];
      end
      if (pend.size() == 2) begin
        if (pend[0].act && !pend[0].rd)
          for (int l = 0; l < 4; l++)
            if (!pend[0].be_n[l]) ref_mem[pend[0].addr][l*9 +: 9] = pend[0].wd[l*9 +: 9];
        void'(pend.pop_front());
      end
      pend.push_back(it);
    end
  endtask

  task automatic wr(string tag, int a, logic [3:0] be_n = 4'h0);
    cyc(tag, 0, 0, 0, a, be_n, SEL_OK, 0);
  endtask
  task automatic rd(string tag, int a);
    cyc(tag, 0, 0, 1, a, 4'h0, SEL_OK, 0);
  endtask
  task automatic adv(string tag);
    cyc(tag, 0, 1, 0, 0, 4'h0, SEL_OK, 0);
  endtask
  task automatic desel(string tag, logic [2:0] sel);
    cyc(tag, 0, 0, 0, 0, 4'h0, sel, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: cycles actual 100000 expected fewer");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) ref_mem[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(data_oe_o === 1'b0, "R11", "reset data_oe_o", {35'd0, data_oe_o}, 36'd0);
    @(negedge clk);
    rst_n = 1'b1;

    adv("R11"); adv("R6"); adv("R6");          // no burst active after reset
    // R1/R4: plain writes then reads
    wr("R1", 8); wr("R4", 9); wr("R1", 10);
    rd("R1", 8); rd("R4", 9); rd("R1", 10);
    // R2: back-to-back alternation, same-address forward
    wr("R2", 12); rd("R2", 12); wr("R2", 13); rd("R2", 8); wr("R2", 12); rd("R2", 12);
    rd("R2", 13);
    // R9: masked rewrite, lanes 0 and 2
    wr("R9", 20); wr("R9", 20, 4'b1010); rd("R9", 20); rd("R9", 20);
    // R5/R6: linear write burst from 5 (5,6,7,4)
    burst_lin_i = 1'b1;
    wr("R5", 5); adv("R6"); adv("R5"); adv("R5");
    rd("R5", 5); adv("R5"); adv("R6"); adv("R5");
    // interleaved read burst from 6 (6,7,4,5)
    cyc("R5", 1, 1, 0, 0, 4'h0, SEL_OK, 0);
    burst_lin_i = 1'b0;
    rd("R5", 6); adv("R5"); adv("R5"); adv("R5"); adv("R5");
    burst_lin_i = 1'b1;
    // R3: stall mid-burst with a conflicting write presented
    rd("R3", 4); adv("R3");
    cyc("R3", 1, 0, 0, 4, 4'h0, SEL_OK, 0);
    cyc("R3", 1, 0, 0, 4, 4'h0, SEL_OK, 0);
    adv("R3"); adv("R3");
    rd("R3", 4);
    // R7/R8: deselect with pending write and read
    wr("R7", 30); rd("R7", 8);
    desel("R7", 3'b110); adv("R6"); desel("R7", 3'b000); desel("R8", 3'b011);
    rd("R7", 30);
    // R10: output enable pulse over a read slot
    rd("R10", 9); rd("R10", 10);
    cyc("R10", 0, 0, 0, 0, 4'h0, 3'b110, 1);
    cyc("R10", 0, 0, 0, 0, 4'h0, 3'b110, 0);
    repeat (3) desel("R8", 3'b110);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule